// File: doc/BRIEF.md
# Video Illegal Code Remapper

This block sits in a 10-bit standard-definition video word path, taking one word per clock. Inside the active picture it replaces the reserved code values at both ends of the range with the nearest legal value. At preamble positions it restores the full 10-bit timing-reference or ancillary-data preamble when an 8-bit source has dropped the two least significant bits. The active-picture flag and the preamble position marker come from upstream timing logic. The block does not regenerate protection bits of timing-reference words.

All words, changed or not, leave the block exactly one clock after they are accepted, and the valid strobe is delayed to match. A bypass input, high for "disabled", passes every word through untouched while keeping the same latency.

Top module: `vid_code_remap`

## Requirements
- R1: With bypass low, no marker (`pre_pos_i` = 0) and `active_i` high, an input word from 3FCh to 3FFh is output as 3FBh.
- R2: With bypass low, no marker and `active_i` high, an input word from 000h to 003h is output as 004h.
- R3: With bypass low and no marker, every word not covered by R1 or R2 (including all words with `active_i` low) is output unchanged.
- R4: With bypass low and `pre_kind_i` = 0 (timing reference), marker positions 1, 2, 3 expect the preamble 3FFh, 000h, 000h; when bits [9:2] of the input equal bits [9:2] of the expected word, the output is the full expected word.
- R5: With bypass low and `pre_kind_i` = 1 (ancillary data), marker positions 1, 2, 3 expect the preamble 000h, 3FFh, 3FFh, with the same matching and output rule as R4.
- R6: With bypass low and a non-zero marker whose expected word does not match in bits [9:2], the word is output unchanged; a marker always takes precedence over the R1/R2 clamp.
- R7: With `bypass_i` high, every word is output unchanged whatever the other control inputs are.
- R8: A word accepted with `valid_i` high appears on `data_o` one clock later, and `valid_o` equals `valid_i` from the previous clock.
- R9: When `valid_i` is low, `data_o` holds its previous value on the next clock.
- R10: During reset `data_o` is 000h and `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 10 | Incoming video word |
| valid_i | input | 1 | Input word strobe |
| active_i | input | 1 | Word lies in the active picture |
| pre_pos_i | input | 2 | Preamble position: 0 none, 1..3 first..third word |
| pre_kind_i | input | 1 | Preamble kind: 0 timing reference, 1 ancillary data |
| bypass_i | input | 1 | High disables all remapping |
| data_o | output | 10 | Corrected video word |
| valid_o | output | 1 | Output word strobe |

## Verification
Every result is due one clock after its word is accepted. The bench drives each word on a falling edge, lets one rising edge capture it, and compares `data_o` and `valid_o` on the next falling edge against a value worked out from the requirements. The hold check drops `valid_i`, changes the data, and looks at the output on the falling edge after the following rising edge. Full 1024-code sweeps cover both states of the active flag, every marker position of both preamble kinds, and the bypass case.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  typedef enum logic [1:0] {
    POS_NONE = 2'd0,
    POS_W0   = 2'd1,
    POS_W1   = 2'd2,
    POS_W2   = 2'd3
  } pre_pos_e;

  typedef enum logic {
    KIND_TRS = 1'b0,
    KIND_ANC = 1'b1
  } pre_kind_e;
endpackage

// File: rtl/vcr_clamp.sv
module vcr_clamp #(
  parameter int DATA_W  = 10,
  parameter int TRUNC_W = 2
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              en_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned BAND = 1 << TRUNC_W;
  localparam logic [DATA_W-1:0] MAX_CODE = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] HI_LIM   = MAX_CODE - DATA_W'(BAND - 1);
  localparam logic [DATA_W-1:0] HI_OUT   = HI_LIM - 1'b1;
  localparam logic [DATA_W-1:0] LO_LIM   = DATA_W'(BAND - 1);
  localparam logic [DATA_W-1:0] LO_OUT   = DATA_W'(BAND);

  always_comb begin
    data_o = data_i;
    if (en_i) begin
      if (data_i >= HI_LIM)      data_o = HI_OUT;
      else if (data_i <= LO_LIM) data_o = LO_OUT;
    end
  end
endmodule

// File: rtl/vcr_preamble.sv
module vcr_preamble
  import vcr_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int TRUNC_W = 2
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        pos_i,
  input  logic              kind_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] word_o
);
  localparam logic [DATA_W-1:0] ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ZEROS = '0;

  logic first_word;

  always_comb begin
    first_word = (pos_i == POS_W0);
    // timing reference starts high, ancillary starts low
    if (kind_i == KIND_TRS) word_o = first_word ? ONES : ZEROS;
    else                    word_o = first_word ? ZEROS : ONES;
    hit_o = (pos_i != POS_NONE) &&
            (data_i[DATA_W-1:TRUNC_W] == word_o[DATA_W-1:TRUNC_W]);
  end
endmodule

// File: rtl/vcr_out_reg.sv
module vcr_out_reg #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/vid_code_remap.sv
module vid_code_remap
  import vcr_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int TRUNC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              active_i,
  input  logic [1:0]        pre_pos_i,
  input  logic              pre_kind_i,
  input  logic              bypass_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam logic [DATA_W-1:0] MAX_CODE = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] HI_LIM   = MAX_CODE - DATA_W'((1 << TRUNC_W) - 1);
  localparam logic [DATA_W-1:0] LO_LIM   = DATA_W'((1 << TRUNC_W) - 1);

  logic              marker;
  logic              pre_hit;
  logic [DATA_W-1:0] pre_word;
  logic [DATA_W-1:0] clamp_word;
  logic [DATA_W-1:0] next_word;

  assign marker = (pre_pos_i != POS_NONE);

  vcr_clamp #(.DATA_W(DATA_W), .TRUNC_W(TRUNC_W)) u_clamp (
    .data_i (data_i),
    .en_i   (active_i && !marker),
    .data_o (clamp_word)
  );

  vcr_preamble #(.DATA_W(DATA_W), .TRUNC_W(TRUNC_W)) u_pre (
    .data_i (data_i),
    .pos_i  (pre_pos_i),
    .kind_i (pre_kind_i),
    .hit_o  (pre_hit),
    .word_o (pre_word)
  );

  always_comb begin
    if (bypass_i)     next_word = data_i;
    else if (marker)  next_word = pre_hit ? pre_word : data_i;
    else              next_word = clamp_word;
  end

  vcr_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (next_word),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  a_r1_high_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !bypass_i && !marker && active_i && data_i >= HI_LIM
    |=> data_o == HI_LIM - 1'b1);

  a_r2_low_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !bypass_i && !marker && active_i && data_i <= LO_LIM
    |=> data_o == LO_LIM + 1'b1);

  a_r3_outside_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !bypass_i && !marker && !active_i
    |=> data_o == $past(data_i));

  a_r4_trs_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !bypass_i && pre_kind_i == KIND_TRS && pre_pos_i == POS_W0 &&
    data_i[DATA_W-1:TRUNC_W] == MAX_CODE[DATA_W-1:TRUNC_W]
    |=> data_o == MAX_CODE);

  a_r5_anc_later: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !bypass_i && pre_kind_i == KIND_ANC && pre_pos_i != POS_W0 &&
    marker && data_i[DATA_W-1:TRUNC_W] == MAX_CODE[DATA_W-1:TRUNC_W]
    |=> data_o == MAX_CODE);

  a_r7_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && bypass_i |=> data_o == $past(data_i));

  a_r8_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));

  always_comb begin
    if (!rst_ni) a_r10_reset: assert (!valid_o && data_o == '0);
  end
endmodule

// File: tb/vid_code_remap_tb.sv
module vid_code_remap_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       active_i = 1'b0;
  logic [1:0] pos_i = '0;
  logic       kind_i = 1'b0;
  logic       byp_i = 1'b0;
  logic [9:0] data_o;
  logic       valid_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  vid_code_remap u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .data_i     (data_i),
    .valid_i    (valid_i),
    .active_i   (active_i),
    .pre_pos_i  (pos_i),
    .pre_kind_i (kind_i),
    .bypass_i   (byp_i),
    .data_o     (data_o),
    .valid_o    (valid_o)
  );

  task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] full_pre(logic kind, logic [1:0] pos);
    if (kind == 1'b0) return (pos == 2'd1) ? 10'h3FF : 10'h000;
    return (pos == 2'd1) ? 10'h000 : 10'h3FF;
  endfunction

  task automatic send(logic [9:0] d, logic act, logic [1:0] pos, logic kind, logic byp);
    logic [9:0] exp;
    string req;
    exp = d;
    if (byp) req = "R7";
    else if (pos != 2'd0) begin
      if (d[9:2] == full_pre(kind, pos)[9:2]) begin
        exp = full_pre(kind, pos);
        req = kind ? "R5" : "R4";
      end else req = "R6";
    end else if (act && d >= 10'h3FC) begin exp = 10'h3FB; req = "R1"; end
    else if (act && d <= 10'h003) begin exp = 10'h004; req = "R2"; end
    else req = "R3";
    @(negedge clk);
    data_i = d; active_i = act; pos_i = pos; kind_i = kind; byp_i = byp; valid_i = 1'b1;
    @(negedge clk);
    chk(req, data_o, exp);
    chk("R8", {9'd0, valid_o}, 10'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", data_o, 10'h000);
    chk("R10", {9'd0, valid_o}, 10'd0);
    rst_n = 1'b1;

    // R1 R2 R3: all codes, active clear then set
    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 1024; c++) send(10'(c), a[0], 2'd0, 1'b0, 1'b0);

    // R4 R5 R6: all codes at every marker position, both kinds, with active set
    for (int k = 0; k < 2; k++)
      for (int p = 1; p < 4; p++)
        for (int c = 0; c < 1024; c++) send(10'(c), 1'b1, 2'(p), k[0], 1'b0);

    // R7: bypass with clamping and marker controls asserted
    for (int c = 0; c < 1024; c++) send(10'(c), 1'b1, 2'(c % 4), c[4], 1'b1);

    // R9: hold while valid is low
    send(10'h155, 1'b0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    valid_i = 1'b0; data_i = 10'h2AA;
    @(negedge clk);
    chk("R9", data_o, 10'h155);
    chk("R8", {9'd0, valid_o}, 10'd0);
    @(negedge clk);
    chk("R9", data_o, 10'h155);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule